// File: doc/BRIEF.md
# Single-Pin GPIO Controller with Interrupt Detection

This block controls one general-purpose pin through a single 32-bit control/status word. Software writes the word through a plain register port (one write strobe, write data, combinational read data). The stored fields drive the pad-control outputs: input enable, Schmitt enable, drive strength, pull-up, pull-down, output enable and a 5-bit alternate-function code. Choosing a peripheral with that code happens outside the block.

The pin output value has four sources, chosen by a 2-bit pin mode. The first is a stored value bit. The second is write-only set and clear strobes, where set wins over clear. The third is a DMA beat that loads the value. The fourth is a DMA beat that can only set the value, while software strobes can still set or clear it.

The pin input feeds an interrupt detector. A synchronous mode family finds edges and levels on the synchronized pin samples. An asynchronous family captures edges with flops clocked by the raw pin, so it also catches pulses shorter than a clock period. Every detection sets a sticky flag. A mask bit gates that flag onto the interrupt line, and a clear bit in the write word resets it.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset every bit of `reg_rdata` is 0, and `pin_oe`, `pin_out`, `irq` and all pad-control outputs are 0.
- R2: A write stores bit 0 (input enable), bit 1 (Schmitt), bits 3:2 (drive), bit 4 (pull-up), bit 5 (pull-down), bit 6 (output enable), bits 12:8 (alternate function), bits 19:16 (interrupt mode), bit 22 (mask) and bits 31:30 (pin mode). It drives the matching pad outputs, and these bits read back unchanged. Bits 20, 25 and 26 always read 0. Bit 28 reads the pin input after a two-flop synchronizer: it follows a change two clock cycles later.
- R3: In pin mode 0, a write loads bit 24 of the write data into the output value. The set/clear strobes in bits 25/26 have no effect, and bit 24 reads back the output value.
- R4: In pin mode 1, write bit 25 sets the output value and write bit 26 clears it. When both are 1, set wins. Write bit 24 is ignored.
- R5: In pin mode 2, a cycle with `dma_valid` high loads `dma_data` into the output value. Register writes do not change the output value.
- R6: In pin mode 3, a DMA beat with `dma_data`=1 sets the output value and a beat with `dma_data`=0 leaves it unchanged. Register strobes set and clear it as in mode 1. A DMA set wins over a register clear in the same cycle.
- R7: `pin_oe` equals the output-enable bit. `pin_out` is the output value while output enable is 1 and is 0 otherwise. The pin mode that applies to a write is the one stored before that write.
- R8: Synchronous edge modes raise the flag (read bit 21): code 0 on a falling edge, code 1 on a rising edge, code 4 on either edge. An edge of the other polarity does not raise it.
- R9: Level modes raise the flag while the pin is low (codes 2 and 10) or high (codes 3 and 11). After a clear, the flag is set again one cycle later if the level is still present.
- R10: Asynchronous edge modes raise the flag: code 8 on a falling edge, code 9 on a rising edge. This includes a pulse that starts and ends between two clock edges, which synchronous mode 1 misses.
- R11: A write with bit 20 set clears the flag in that cycle. The clear takes priority over a detection in the same cycle.
- R12: `irq` is the flag gated by NOT mask. While the mask is 1, `irq` stays 0 but the flag still latches.
- R13: Interrupt codes 5, 6, 7 and 12 to 15 never raise the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| dma_valid | input | 1 | DMA beat valid |
| dma_data | input | 1 | DMA output bit |
| pin_in | input | 1 | Raw pin input (asynchronous) |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |
| pad_ie | output | 1 | Pad input enable |
| pad_smt | output | 1 | Pad Schmitt enable |
| pad_drv | output | 2 | Pad drive strength |
| pad_pu | output | 1 | Pad pull-up enable |
| pad_pd | output | 1 | Pad pull-down enable |
| pad_alt | output | 5 | Alternate-function code |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following:
- the mask keeps `irq` low;
- a clear write empties the flag on the next cycle;
- set wins over clear in strobe mode;
- mode-0 value writes and mode-2 DMA beats reach the output;
- `pin_out` stays low without output enable.

Only the bench scenarios show the timing-dependent interrupt behaviour: which edge polarities each mode accepts, a sub-cycle pulse caught by the asynchronous family and missed by the synchronous one, a level flag returning after a clear, and silence in the unused codes. The bench scenarios also cover the mode-3 DMA/strobe interplay and the two-cycle input latency.

// File: rtl/gpio_pin_pkg.sv
`timescale 1ns/1ps
// Package: field positions, pin-mode and interrupt-mode codes and the
// stored-configuration struct shared by the GPIO pin controller modules.
package gpio_pin_pkg;
    localparam int REG_W      = 32;
    localparam int DRV_W      = 2;
    localparam int ALT_W      = 5;
    localparam int IMODE_W    = 4;
    localparam int PMODE_W    = 2;

    localparam int B_IE       = 0;
    localparam int B_SMT      = 1;
    localparam int B_DRV      = 2;
    localparam int B_PU       = 4;
    localparam int B_PD       = 5;
    localparam int B_OE       = 6;
    localparam int B_ALT      = 8;
    localparam int B_IMODE    = 16;
    localparam int B_ICLR     = 20;
    localparam int B_IFLAG    = 21;
    localparam int B_IMASK    = 22;
    localparam int B_OVAL     = 24;
    localparam int B_OSET     = 25;
    localparam int B_OCLR     = 26;
    localparam int B_IVAL     = 28;
    localparam int B_PMODE    = 30;

    typedef enum logic [PMODE_W-1:0] {
        PM_VALUE      = 2'd0,
        PM_STROBE     = 2'd1,
        PM_DMA_VALUE  = 2'd2,
        PM_DMA_STROBE = 2'd3
    } pin_mode_e;

    localparam logic [IMODE_W-1:0] IM_S_FALL = 4'd0;
    localparam logic [IMODE_W-1:0] IM_S_RISE = 4'd1;
    localparam logic [IMODE_W-1:0] IM_S_LOW  = 4'd2;
    localparam logic [IMODE_W-1:0] IM_S_HIGH = 4'd3;
    localparam logic [IMODE_W-1:0] IM_S_BOTH = 4'd4;
    localparam logic [IMODE_W-1:0] IM_A_FALL = 4'd8;
    localparam logic [IMODE_W-1:0] IM_A_RISE = 4'd9;
    localparam logic [IMODE_W-1:0] IM_A_LOW  = 4'd10;
    localparam logic [IMODE_W-1:0] IM_A_HIGH = 4'd11;

    typedef struct packed {
        logic                ie;
        logic                smt;
        logic [DRV_W-1:0]    drv;
        logic                pu;
        logic                pd;
        logic                oe;
        logic [ALT_W-1:0]    alt;
        logic [IMODE_W-1:0]  imode;
        logic                imask;
        pin_mode_e           pmode;
    } pin_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for WIDTH independent single-bit signals.
// Assumes STAGES >= 2 and that each bit may change at any time.
module gpio_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
`timescale 1ns/1ps
// Stored configuration fields of the pin control word.
// Assumes the write strobe is a single-cycle pulse in the clk domain;
// strobe and read-only bit positions are dropped here.
module gpio_cfg_regs
    import gpio_pin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output pin_cfg_t         cfg
);
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[7], wr_data[15:13], wr_data[21:20],
                              wr_data[29:23]};

    // Capture the stored fields on a write; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.ie    <= wr_data[B_IE];
            cfg.smt   <= wr_data[B_SMT];
            cfg.drv   <= wr_data[B_DRV +: DRV_W];
            cfg.pu    <= wr_data[B_PU];
            cfg.pd    <= wr_data[B_PD];
            cfg.oe    <= wr_data[B_OE];
            cfg.alt   <= wr_data[B_ALT +: ALT_W];
            cfg.imode <= wr_data[B_IMODE +: IMODE_W];
            cfg.imask <= wr_data[B_IMASK];
            cfg.pmode <= pin_mode_e'(wr_data[B_PMODE +: PMODE_W]);
        end
    end
endmodule

// File: rtl/gpio_out_ctrl.sv
`timescale 1ns/1ps
// Output-value register and its four source modes.
// The mode used is the one stored before the current write. DMA beats
// and register strobes arriving in the same cycle are resolved here.
module gpio_out_ctrl
    import gpio_pin_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_e mode,
    input  logic      wr_en,
    input  logic      wr_val,
    input  logic      wr_set,
    input  logic      wr_clr,
    input  logic      dma_valid,
    input  logic      dma_data,
    output logic      out_val
);
    logic strobe_set, strobe_clr;
    assign strobe_set = wr_en & wr_set;
    assign strobe_clr = wr_en & wr_clr;

    // Update the output value from the source the pin mode selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_val <= 1'b0;
        end else begin
            unique case (mode)
                PM_VALUE: begin
                    if (wr_en) out_val <= wr_val;
                end
                PM_STROBE: begin
                    if (strobe_set)      out_val <= 1'b1;
                    else if (strobe_clr) out_val <= 1'b0;
                end
                PM_DMA_VALUE: begin
                    if (dma_valid) out_val <= dma_data;
                end
                PM_DMA_STROBE: begin
                    if ((dma_valid && dma_data) || strobe_set) out_val <= 1'b1;
                    else if (strobe_clr)                       out_val <= 1'b0;
                end
                default: out_val <= out_val;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
// Interrupt detector with a sticky flag.
// Synchronous modes compare successive synchronized pin samples.
// Asynchronous edge modes toggle a flop on the raw pin edge and
// resynchronize the toggle. Level modes in both families use the
// synchronized level. The toggle flops are cleared through a registered
// copy of the reset, so reset must be held for at least two cycles.
module gpio_irq_detect
    import gpio_pin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_raw,
    input  logic [IMODE_W-1:0] mode,
    input  logic               clr,
    output logic               pin_level,
    output logic               flag
);
    localparam int N_TGL = 2;

    logic              pin_prev;
    logic              arm_q;
    logic              rise_tgl, fall_tgl;
    logic [N_TGL-1:0]  tgl_s, tgl_h, tgl_evt;
    logic              s_rise, s_fall, hit;

    gpio_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_level)
    );

    // Registered reset copy that clears the pin-clocked toggle flops.
    always_ff @(posedge clk) arm_q <= rst_n;

    // Toggle on every raw rising edge of the pin.
    always_ff @(posedge pin_raw or negedge arm_q) begin
        if (!arm_q) rise_tgl <= 1'b0;
        else        rise_tgl <= ~rise_tgl;
    end

    // Toggle on every raw falling edge of the pin.
    always_ff @(negedge pin_raw or negedge arm_q) begin
        if (!arm_q) fall_tgl <= 1'b0;
        else        fall_tgl <= ~fall_tgl;
    end

    gpio_sync #(.WIDTH(N_TGL), .STAGES(SYNC_STAGES)) u_tgl_sync (
        .clk(clk), .rst_n(rst_n), .d({fall_tgl, rise_tgl}), .q(tgl_s)
    );

    // Keep the previous synchronized sample and toggle states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_prev <= 1'b0;
            tgl_h    <= '0;
        end else begin
            pin_prev <= pin_level;
            tgl_h    <= tgl_s;
        end
    end

    assign s_rise  = pin_level & ~pin_prev;
    assign s_fall  = ~pin_level & pin_prev;
    assign tgl_evt = tgl_s ^ tgl_h;

    // Pick the detection condition for the selected interrupt mode.
    always_comb begin
        unique case (mode)
            IM_S_FALL: hit = s_fall;
            IM_S_RISE: hit = s_rise;
            IM_S_LOW:  hit = ~pin_level;
            IM_S_HIGH: hit = pin_level;
            IM_S_BOTH: hit = s_rise | s_fall;
            IM_A_FALL: hit = tgl_evt[1];
            IM_A_RISE: hit = tgl_evt[0];
            IM_A_LOW:  hit = ~pin_level;
            IM_A_HIGH: hit = pin_level;
            default:   hit = 1'b0;
        endcase
    end

    // Sticky flag: clear has priority, then any detection sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (clr) flag <= 1'b0;
        else if (hit) flag <= 1'b1;
    end
endmodule

// File: rtl/gpio_pin_ctrl.sv
`timescale 1ns/1ps
// Top of the single-pin GPIO controller: one control/status word, pad
// control outputs, output-value sourcing and interrupt generation.
// Assumes a single clock domain apart from the raw pin input.
module gpio_pin_ctrl
    import gpio_pin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             dma_valid,
    input  logic             dma_data,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             pad_ie,
    output logic             pad_smt,
    output logic [DRV_W-1:0] pad_drv,
    output logic             pad_pu,
    output logic             pad_pd,
    output logic [ALT_W-1:0] pad_alt,
    output logic             irq
);
    pin_cfg_t cfg;
    logic     out_val;
    logic     pin_level;
    logic     flag;

    gpio_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_data(reg_wdata),
        .cfg(cfg)
    );

    gpio_out_ctrl u_out (
        .clk(clk), .rst_n(rst_n), .mode(cfg.pmode),
        .wr_en(reg_we), .wr_val(reg_wdata[B_OVAL]),
        .wr_set(reg_wdata[B_OSET]), .wr_clr(reg_wdata[B_OCLR]),
        .dma_valid(dma_valid), .dma_data(dma_data), .out_val(out_val)
    );

    gpio_irq_detect #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_in), .mode(cfg.imode),
        .clr(reg_we & reg_wdata[B_ICLR]), .pin_level(pin_level),
        .flag(flag)
    );

    // Assemble the read word from stored fields and live status.
    always_comb begin
        reg_rdata                      = '0;
        reg_rdata[B_IE]                = cfg.ie;
        reg_rdata[B_SMT]               = cfg.smt;
        reg_rdata[B_DRV +: DRV_W]      = cfg.drv;
        reg_rdata[B_PU]                = cfg.pu;
        reg_rdata[B_PD]                = cfg.pd;
        reg_rdata[B_OE]                = cfg.oe;
        reg_rdata[B_ALT +: ALT_W]      = cfg.alt;
        reg_rdata[B_IMODE +: IMODE_W]  = cfg.imode;
        reg_rdata[B_IFLAG]             = flag;
        reg_rdata[B_IMASK]             = cfg.imask;
        reg_rdata[B_OVAL]              = out_val;
        reg_rdata[B_IVAL]              = pin_level;
        reg_rdata[B_PMODE +: PMODE_W]  = cfg.pmode;
    end

    assign pad_ie  = cfg.ie;
    assign pad_smt = cfg.smt;
    assign pad_drv = cfg.drv;
    assign pad_pu  = cfg.pu;
    assign pad_pd  = cfg.pd;
    assign pad_alt = cfg.alt;
    assign pin_oe  = cfg.oe;
    assign pin_out = out_val & cfg.oe;
    assign irq     = flag & ~cfg.imask;
endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
`timescale 1ns/1ps
// Checker bound to the top: port-level temporal properties of the output
// sources, the mask, the clear and the output gating.
module gpio_pin_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        dma_valid,
    input logic        dma_data,
    input logic        pin_out,
    input logic        pin_oe,
    input logic        irq
);
    logic unused_chk;
    assign unused_chk = ^{reg_wdata, reg_rdata};

    // R12: a set mask keeps the interrupt line low
    a_r12_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[22] |-> !irq);

    // R11: a clear write empties the flag at the next cycle
    a_r11_clear_empties_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wdata[20]) |=> !reg_rdata[21]);

    // R4: in strobe mode a set strobe wins
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_rdata[31:30] == 2'd1 && reg_wdata[25]) |=> reg_rdata[24]);

    // R4: a lone clear strobe lowers the value
    a_r4_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_rdata[31:30] == 2'd1 && reg_wdata[26] && !reg_wdata[25])
        |=> !reg_rdata[24]);

    // R3: value writes in mode 0 reach the output value
    a_r3_value_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_rdata[31:30] == 2'd0) |=> reg_rdata[24] == $past(reg_wdata[24]));

    // R5: DMA beats in mode 2 load the output value
    a_r5_dma_value: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && reg_rdata[31:30] == 2'd2) |=> reg_rdata[24] == $past(dma_data));

    // R7: no output drive without output enable
    a_r7_oe_gates_out: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_out);
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk u_chk (.*);

// File: tb/gpio_pin_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_pin_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dma_valid = 1'b0;
    logic        dma_data = 1'b0;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe, pad_ie, pad_smt, pad_pu, pad_pd, irq;
    logic [1:0]  pad_drv;
    logic [4:0]  pad_alt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    gpio_pin_ctrl u_gpio_pin_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dma_valid(dma_valid), .dma_data(dma_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pad_ie(pad_ie), .pad_smt(pad_smt), .pad_drv(pad_drv),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_alt(pad_alt), .irq(irq)
    );

    // Stored-bit mask from R2: bits 6:0, 12:8, 19:16, 22, 31:30.
    localparam logic [31:0] STORED = 32'hC04F_1F7F;

    function automatic logic [31:0] mk(input logic [3:0] im, input logic msk,
                                       input logic [1:0] pm, input logic oe,
                                       input logic val, input logic st,
                                       input logic cl, input logic ic);
        logic [31:0] w = '0;
        w[6] = oe; w[19:16] = im; w[20] = ic; w[22] = msk;
        w[24] = val; w[25] = st; w[26] = cl; w[31:30] = pm;
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic dma(input logic d);
        @(negedge clk);
        dma_valid = 1'b1; dma_data = d;
        @(negedge clk);
        dma_valid = 1'b0; dma_data = 1'b0;
    endtask

    task automatic arm(input logic [3:0] im, input logic msk);
        wr(mk(im, msk, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        tick(4);
        wr(mk(im, msk, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    endtask

    task automatic short_pulse();
        @(posedge clk);
        #1 pin_in = 1'b1;
        #1 pin_in = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        exp_out;
        logic [1:0]  cur_mode;
        void'($urandom(32'd5150));
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 outs", {pin_oe, pin_out, irq, pad_ie, pad_smt, pad_drv, pad_pu, pad_pd, pad_alt},
            '0);

        // R2/R3/R7: field storage, strobe bits read 0, pad outputs
        d = 32'h0013_1B5B | (32'h1 << 24) | (32'h7 << 20) | (32'h3 << 25);
        d[20] = 1'b1; d[21] = 1'b0; d[22] = 1'b0; d[23] = 1'b0;
        d[19:16] = 4'd5;
        wr(d);
        chk("R2 readback", reg_rdata, (d & STORED) | (32'h1 << 24));
        chk("R2 pads", {pad_ie, pad_smt, pad_drv, pad_pu, pad_pd, pad_alt},
            {d[0], d[1], d[3:2], d[4], d[5], d[12:8]});
        chk("R3 value bit", reg_rdata[24], 1'b1);
        chk("R7 oe/out", {pin_oe, pin_out}, 2'b11);

        // R2: input readback through two-flop synchronizer
        pin_in = 1'b1;
        tick(1);
        chk("R2 input latency 1", reg_rdata[28], 1'b0);
        tick(1);
        chk("R2 input latency 2", reg_rdata[28], 1'b1);
        pin_in = 1'b0;
        tick(3);

        // R13: unused interrupt codes stay silent
        for (int c = 5; c < 16; c++) begin
            if (c >= 8 && c <= 11) continue;
            arm(4'(c), 1'b0);
            pin_in = 1'b1; tick(4);
            pin_in = 1'b0; tick(4);
            short_pulse(); tick(6);
            chk($sformatf("R13 code %0d", c), reg_rdata[21], 1'b0);
        end

        // R8: synchronous edge modes
        arm(4'd0, 1'b0);
        pin_in = 1'b1; tick(5);
        chk("R8 fall ignores rise", reg_rdata[21], 1'b0);
        pin_in = 1'b0; tick(5);
        chk("R8 fall detected", reg_rdata[21], 1'b1);
        arm(4'd1, 1'b0);
        pin_in = 1'b1; tick(5);
        chk("R8 rise detected", {reg_rdata[21], irq}, 2'b11);
        arm(4'd4, 1'b0);
        pin_in = 1'b0; tick(5);
        chk("R8 both on fall", reg_rdata[21], 1'b1);
        wr(mk(4'd4, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        pin_in = 1'b1; tick(5);
        chk("R8 both on rise", reg_rdata[21], 1'b1);

        // R9/R11: level re-set after clear; clear beats detection
        arm(4'd3, 1'b0);
        chk("R11 clear beats level", reg_rdata[21], 1'b0);
        tick(1);
        chk("R9 high level re-sets", reg_rdata[21], 1'b1);

        // R12: mask gates irq, flag still latches
        wr(mk(4'd3, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        tick(1);
        chk("R12 masked flag/irq", {reg_rdata[21], irq}, 2'b10);
        wr(mk(4'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        chk("R12 unmasked irq", irq, 1'b1);

        // R9: asynchronous low level
        pin_in = 1'b0; tick(3);
        arm(4'd10, 1'b0);
        tick(1);
        chk("R9 async low level", reg_rdata[21], 1'b1);

        // R10: sub-cycle pulse caught asynchronously, missed synchronously
        arm(4'd9, 1'b0);
        short_pulse(); tick(6);
        chk("R10 async rise pulse", reg_rdata[21], 1'b1);
        arm(4'd8, 1'b0);
        short_pulse(); tick(6);
        chk("R10 async fall pulse", reg_rdata[21], 1'b1);
        arm(4'd1, 1'b0);
        short_pulse(); tick(6);
        chk("R10 sync misses pulse", reg_rdata[21], 1'b0);

        // R4: strobe mode
        wr(mk(4'd5, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
        wr(mk(4'd5, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
        chk("R4 set", reg_rdata[24], 1'b1);
        wr(mk(4'd5, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0));
        chk("R4 clear, value bit ignored", reg_rdata[24], 1'b0);
        wr(mk(4'd5, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0));
        chk("R4 set wins", reg_rdata[24], 1'b1);

        // R5: DMA value mode
        wr(mk(4'd5, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        dma(1'b0);
        chk("R5 dma 0", reg_rdata[24], 1'b0);
        wr(mk(4'd5, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0));
        chk("R5 reg write ignored", {reg_rdata[24], pin_out}, 2'b00);
        dma(1'b1);
        chk("R5 dma 1", pin_out, 1'b1);

        // R6: DMA set mode
        wr(mk(4'd5, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
        chk("R6 entry write under mode 2", reg_rdata[24], 1'b1);
        dma(1'b0);
        chk("R6 dma 0 no change", reg_rdata[24], 1'b1);
        wr(mk(4'd5, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
        chk("R6 reg clear", reg_rdata[24], 1'b0);
        dma(1'b1);
        chk("R6 dma set", reg_rdata[24], 1'b1);
        wr(mk(4'd5, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = mk(4'd5, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        dma_valid = 1'b1; dma_data = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; dma_valid = 1'b0; dma_data = 1'b0;
        chk("R6 dma set beats reg clear", reg_rdata[24], 1'b1);

        // R7: output enable gating
        wr(mk(4'd5, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        chk("R7 oe off", {pin_oe, pin_out, reg_rdata[24]}, 3'b001);

        // R2/R3/R4/R7: random writes in modes 0 and 1
        wr(mk(4'd5, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
        exp_out  = 1'b0;
        cur_mode = 2'd0;
        for (int i = 0; i < 300; i++) begin
            d = $urandom();
            d[19:16] = 4'd5;
            d[20] = 1'b1;
            d[31:30] = {1'b0, d[30]};
            wr(d);
            if (cur_mode == 2'd0)  exp_out = d[24];
            else if (d[25])        exp_out = 1'b1;
            else if (d[26])        exp_out = 1'b0;
            cur_mode = d[31:30];
            chk("R2 random readback", reg_rdata & ~32'h1000_0000,
                (d & STORED) | ({31'b0, exp_out} << 24));
            chk("R7 random pin_out", pin_out, exp_out & d[6]);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule